// File: doc/BRIEF.md
# Multi-Size Fully Associative Translation Lookup

This block translates 64-bit virtual addresses through a fully associative table of 64 translation entries. Each entry pairs a tag, which is a virtual page number with a 13-bit address-space context in its low bits, with a translation word. The translation word carries a valid flag, a page-size code, privilege and write flags, and the physical page bits. The page-size code chooses one of four page sizes: 8 KB, 64 KB, 512 KB or 4 MB. The compare mask is therefore chosen separately for every entry. Entries are loaded one at a time through a write port. Software miss handling and replacement are left to the surrounding logic.

A request carries an address, a write flag, a user flag and an instruction-fetch flag. The block registers the result one cycle later. The result is one of four outcomes: a hit with a physical address and rights, a miss, a protection fault, or a pass-through when translation is disabled. A protection fault updates a 4-bit status register and a fault address register. A second fault arriving while the status register is still nonzero is flagged as an overflow.

The controller is a five-state machine, and its state is the registered outcome of the previous cycle:
- `ST_IDLE`: no request was made.
- `ST_HIT`: a matching entry passed its checks.
- `ST_MISS`: no entry matched.
- `ST_FAULT`: the matching entry failed a check.
- `ST_PASS`: translation was disabled.

Every state may move to every other state. On each clock edge the transition is chosen by the request in that cycle, in this order:
1. No request: go to `ST_IDLE`.
2. Translation disabled: go to `ST_PASS`.
3. No tag match: go to `ST_MISS`.
4. A check fails: go to `ST_FAULT`.
5. Otherwise: go to `ST_HIT`.

Top module: `vtlb_lookup`

## Requirements
- R1: A request sampled at a rising edge produces exactly one of `rsp_hit`, `rsp_miss`, `rsp_fault` or `rsp_bypass`, together with `rsp_valid`, after that edge. All five are low in a cycle that follows no request and after reset.
- R2: Translation-word bits [62:61] set the compare mask. Code 0 compares address bits 63..13, code 1 bits 63..16, code 2 bits 63..19, and code 3 bits 63..22.
- R3: An entry matches only when tag bits [12:0] equal `ctx` and the masked address equals the tag with bits [12:0] cleared.
- R4: When several entries match, the entry with the lowest index is used.
- R5: On a hit, `rsp_paddr` takes the translation-word bits inside the mask and the address bits outside it. Only bits [40:12] are kept; every other bit is zero.
- R6: A data hit grants read, and grants write only when translation-word bit 1 is set. A fetch hit grants execute only. The rights are reported as `rsp_rd`, `rsp_wr` and `rsp_ex`.
- R7: A matching entry faults when any of these holds:
  - bit 63 is clear;
  - bit 2 is set and the request is a user access;
  - the request is a data write and bit 1 is clear.

  Entries hold all-zero words after reset.
- R8: A fault sets `fsr` to {user, write, overflow, 1}, from bit 3 down to bit 0. Overflow is 1 when `fsr` was nonzero before the fault. The same fault loads `far` with the address. Nothing else changes either register except the clear input.
- R9: When no entry matches, the result is a miss. On a miss or a fault, `rsp_paddr` and all rights are zero.
- R10: With `xl_en` low, the result is a pass-through: the full address is returned unchanged. A data access gets read and write rights; a fetch gets execute only.
- R11: An entry written at one edge through the write port takes part in a lookup at the next edge.
- R12: `fsr_clr` zeroes `fsr`. When a clear and a fault coincide, the fault is recorded without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xl_en | input | 1 | Translation enable |
| ctx | input | 13 | Current address-space context |
| wr_en | input | 1 | Load an entry |
| wr_idx | input | 6 | Entry index to load |
| wr_tag | input | 64 | Tag to load |
| wr_tte | input | 64 | Translation word to load |
| req_valid | input | 1 | Lookup request |
| req_addr | input | 64 | Virtual address |
| req_write | input | 1 | Data write access |
| req_user | input | 1 | User-mode access |
| req_fetch | input | 1 | Instruction fetch access |
| fsr_clr | input | 1 | Clear fault status |
| rsp_valid | output | 1 | Result present |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | No entry matched |
| rsp_fault | output | 1 | Protection fault |
| rsp_bypass | output | 1 | Translation disabled, address passed through |
| rsp_paddr | output | 64 | Physical address |
| rsp_rd | output | 1 | Read right |
| rsp_wr | output | 1 | Write right |
| rsp_ex | output | 1 | Execute right |
| fsr | output | 4 | Fault status {user, write, overflow, fault} |
| far | output | 64 | Address of the last fault |

## Verification
The assertions take a few things for granted about the inputs:
- `req_valid` is low while reset is held and in the cycle reset is released, so every `$past` term refers to post-reset values.
- `fsr_clr` is a single-cycle pulse.
- `ctx` and `xl_en` are stable around each request.

The stimulus follows these rules by driving every input on the falling edge and holding `req_valid` low through reset. Every tag is loaded with its in-page bits cleared for its page size. Only one directed check, the one that exercises the reset contents of the table, uses context 0.

// File: rtl/vtlb_pkg.sv
package vtlb_pkg;
    localparam int unsigned VA_W      = 64;
    localparam int unsigned CTX_W     = 13;
    localparam int unsigned FSR_W     = 4;
    localparam int unsigned V_BIT     = 63;
    localparam int unsigned SZ_MSB    = 62;
    localparam int unsigned SZ_LSB    = 61;
    localparam int unsigned PRIV_BIT  = 2;
    localparam int unsigned WR_BIT    = 1;
    localparam int unsigned MASK_BASE = 13;
    localparam int unsigned MASK_STEP = 3;
    localparam logic [VA_W-1:0] PA_KEEP = 64'h0000_01FF_FFFF_F000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HIT,
        ST_MISS,
        ST_FAULT,
        ST_PASS
    } vtlb_state_e;

    function automatic logic [VA_W-1:0] size_mask(input logic [1:0] sz);
        int unsigned sh;
        sh = MASK_BASE + MASK_STEP * int'(sz);
        return ~((64'd1 << sh) - 64'd1);
    endfunction
endpackage

// File: rtl/vtlb_cam.sv
module vtlb_cam
    import vtlb_pkg::*;
#(
    parameter int unsigned N_ENT = 64
) (
    input  logic [VA_W-1:0]  tag   [N_ENT],
    input  logic [1:0]       sz    [N_ENT],
    input  logic [CTX_W-1:0] ctx,
    input  logic [VA_W-1:0]  addr,
    output logic [N_ENT-1:0] hit_vec
);
    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        logic ctx_eq;
        logic va_eq;
        assign ctx_eq     = (tag[g][CTX_W-1:0] == ctx);
        assign va_eq      = ((addr & size_mask(sz[g])) == {tag[g][VA_W-1:CTX_W], {CTX_W{1'b0}}});
        assign hit_vec[g] = ctx_eq && va_eq;
    end
endmodule

// File: rtl/vtlb_pick.sv
module vtlb_pick #(
    parameter int unsigned N_ENT = 64,
    localparam int unsigned IDX_W = $clog2(N_ENT)
) (
    input  logic [N_ENT-1:0] hit_vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/vtlb_fsr.sv
module vtlb_fsr
    import vtlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fault_evt,
    input  logic             acc_user,
    input  logic             acc_write,
    input  logic [VA_W-1:0]  acc_addr,
    input  logic             clr,
    output logic [FSR_W-1:0] fsr_q,
    output logic [VA_W-1:0]  far_q
);
    logic ovf;
    assign ovf = (fsr_q != '0) && !clr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsr_q <= '0;
            far_q <= '0;
        end else if (fault_evt) begin
            fsr_q <= {acc_user, acc_write, ovf, 1'b1};
            far_q <= acc_addr;
        end else if (clr) begin
            fsr_q <= '0;
        end
    end
endmodule

// File: rtl/vtlb_lookup.sv
module vtlb_lookup
    import vtlb_pkg::*;
#(
    parameter int unsigned N_ENT = 64,
    localparam int unsigned IDX_W = $clog2(N_ENT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xl_en,
    input  logic [CTX_W-1:0] ctx,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VA_W-1:0]  wr_tag,
    input  logic [VA_W-1:0]  wr_tte,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_addr,
    input  logic             req_write,
    input  logic             req_user,
    input  logic             req_fetch,
    input  logic             fsr_clr,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_miss,
    output logic             rsp_fault,
    output logic             rsp_bypass,
    output logic [VA_W-1:0]  rsp_paddr,
    output logic             rsp_rd,
    output logic             rsp_wr,
    output logic             rsp_ex,
    output logic [FSR_W-1:0] fsr,
    output logic [VA_W-1:0]  far
);
    logic [VA_W-1:0]  tag_q [N_ENT];
    logic [VA_W-1:0]  tte_q [N_ENT];
    logic [1:0]       sz_w  [N_ENT];
    logic [N_ENT-1:0] hit_vec;
    logic             any_hit;
    logic [IDX_W-1:0] win_idx;
    logic [VA_W-1:0]  win_tte;
    logic [VA_W-1:0]  win_mask;
    logic [VA_W-1:0]  pa_calc;
    logic             data_wr;
    logic             viol;
    logic             fault_evt;
    vtlb_state_e      state_q, state_d;
    logic [VA_W-1:0]  pa_q, pa_d;
    logic [2:0]       perm_q, perm_d;

    // Entry storage and write port (R11)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_ENT; i++) begin
                tag_q[i] <= '0;
                tte_q[i] <= '0;
            end
        end else if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
            tte_q[wr_idx] <= wr_tte;
        end
    end

    for (genvar g = 0; g < N_ENT; g++) begin : g_sz
        assign sz_w[g] = tte_q[g][SZ_MSB:SZ_LSB];
    end

    vtlb_cam #(.N_ENT(N_ENT)) u_cam (
        .tag     (tag_q),
        .sz      (sz_w),
        .ctx     (ctx),
        .addr    (req_addr),
        .hit_vec (hit_vec)
    );

    vtlb_pick #(.N_ENT(N_ENT)) u_pick (
        .hit_vec (hit_vec),
        .found   (any_hit),
        .idx     (win_idx)
    );

    assign win_tte   = tte_q[win_idx];
    assign win_mask  = size_mask(win_tte[SZ_MSB:SZ_LSB]);
    assign pa_calc   = ((win_tte & win_mask) | (req_addr & ~win_mask)) & PA_KEEP;
    assign data_wr   = req_write && !req_fetch;
    assign viol      = !win_tte[V_BIT] || (win_tte[PRIV_BIT] && req_user)
                       || (data_wr && !win_tte[WR_BIT]);
    assign fault_evt = req_valid && xl_en && any_hit && viol;

    vtlb_fsr u_fsr (
        .clk       (clk),
        .rst_n     (rst_n),
        .fault_evt (fault_evt),
        .acc_user  (req_user),
        .acc_write (data_wr),
        .acc_addr  (req_addr),
        .clr       (fsr_clr),
        .fsr_q     (fsr),
        .far_q     (far)
    );

    // Next-state selection: outcome of this cycle's request
    always_comb begin
        if (!req_valid)    state_d = ST_IDLE;
        else if (!xl_en)   state_d = ST_PASS;
        else if (!any_hit) state_d = ST_MISS;
        else if (viol)     state_d = ST_FAULT;
        else               state_d = ST_HIT;
    end

    always_comb begin
        if (!xl_en) begin
            pa_d   = req_addr;
            perm_d = req_fetch ? 3'b001 : 3'b110;
        end else begin
            pa_d   = pa_calc;
            perm_d = req_fetch ? 3'b001 : {1'b1, win_tte[WR_BIT], 1'b0};
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pa_q    <= '0;
            perm_q  <= '0;
        end else begin
            state_q <= state_d;
            pa_q    <= pa_d;
            perm_q  <= perm_d;
        end
    end

    // Output decode
    always_comb begin
        rsp_valid  = 1'b1;
        rsp_hit    = 1'b0;
        rsp_miss   = 1'b0;
        rsp_fault  = 1'b0;
        rsp_bypass = 1'b0;
        rsp_paddr  = '0;
        {rsp_rd, rsp_wr, rsp_ex} = 3'b000;
        unique case (state_q)
            ST_IDLE:  rsp_valid = 1'b0;
            ST_HIT: begin
                rsp_hit   = 1'b1;
                rsp_paddr = pa_q;
                {rsp_rd, rsp_wr, rsp_ex} = perm_q;
            end
            ST_MISS:  rsp_miss  = 1'b1;
            ST_FAULT: rsp_fault = 1'b1;
            ST_PASS: begin
                rsp_bypass = 1'b1;
                rsp_paddr  = pa_q;
                {rsp_rd, rsp_wr, rsp_ex} = perm_q;
            end
            default:  rsp_valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/vtlb_lookup_chk.sv
module vtlb_lookup_chk
    import vtlb_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             xl_en,
    input logic             req_valid,
    input logic [VA_W-1:0]  req_addr,
    input logic             req_fetch,
    input logic             fsr_clr,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic             rsp_miss,
    input logic             rsp_fault,
    input logic             rsp_bypass,
    input logic [VA_W-1:0]  rsp_paddr,
    input logic             rsp_rd,
    input logic             rsp_wr,
    input logic             rsp_ex,
    input logic [FSR_W-1:0] fsr,
    input logic [VA_W-1:0]  far
);
    assert_rsp_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_rsp_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    assert_one_outcome_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid == ($countones({rsp_hit, rsp_miss, rsp_fault, rsp_bypass}) == 1));
    assert_pa_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (rsp_paddr[11:0] == 12'h0) && (rsp_paddr[63:41] == 23'h0));
    assert_fetch_rights_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit && $past(req_fetch) |-> rsp_ex && !rsp_rd && !rsp_wr);
    assert_fault_logged_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> fsr[0] && (far == $past(req_addr)));
    assert_fsr_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_fault && !$past(fsr_clr) |-> $stable(fsr) && $stable(far));
    assert_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault && ($past(fsr) != 4'h0) && !$past(fsr_clr) |-> fsr[1]);
    assert_miss_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss || rsp_fault |-> (rsp_paddr == 64'h0) && !rsp_rd && !rsp_wr && !rsp_ex);
    assert_bypass_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !xl_en |=> rsp_bypass && (rsp_paddr == $past(req_addr)));
    assert_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
        fsr_clr && !req_valid |=> fsr == 4'h0);
endmodule

bind vtlb_lookup vtlb_lookup_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .xl_en      (xl_en),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_fetch  (req_fetch),
    .fsr_clr    (fsr_clr),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_miss   (rsp_miss),
    .rsp_fault  (rsp_fault),
    .rsp_bypass (rsp_bypass),
    .rsp_paddr  (rsp_paddr),
    .rsp_rd     (rsp_rd),
    .rsp_wr     (rsp_wr),
    .rsp_ex     (rsp_ex),
    .fsr        (fsr),
    .far        (far)
);

// File: tb/vtlb_lookup_tb.sv
`timescale 1ns/1ps
module vtlb_lookup_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        xl_en;
    logic [12:0] ctx;
    logic        wr_en;
    logic [5:0]  wr_idx;
    logic [63:0] wr_tag, wr_tte;
    logic        req_valid, req_write, req_user, req_fetch, fsr_clr;
    logic [63:0] req_addr;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_bypass;
    logic [63:0] rsp_paddr;
    logic        rsp_rd, rsp_wr, rsp_ex;
    logic [3:0]  fsr;
    logic [63:0] far;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    vtlb_lookup u_dut (
        .clk(clk), .rst_n(rst_n), .xl_en(xl_en), .ctx(ctx),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_tte(wr_tte),
        .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
        .req_user(req_user), .req_fetch(req_fetch), .fsr_clr(fsr_clr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_fault(rsp_fault), .rsp_bypass(rsp_bypass), .rsp_paddr(rsp_paddr),
        .rsp_rd(rsp_rd), .rsp_wr(rsp_wr), .rsp_ex(rsp_ex), .fsr(fsr), .far(far)
    );

    // outcome one-hot {hit, miss, fault, pass}
    localparam logic [3:0] K_HIT = 4'b1000, K_MISS = 4'b0100, K_FLT = 4'b0010, K_PASS = 4'b0001;

    typedef struct packed {
        logic [63:0] addr;
        logic [12:0] cx;
        logic        wr;
        logic        usr;
        logic        fet;
        logic [3:0]  kind;
        logic [63:0] pa;
        logic [2:0]  perm;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{64'h0000_0000_0040_1ABC, 13'd7, 1'b1, 1'b1, 1'b0, K_HIT,  64'h1234_7000, 3'b110}, // R2 8K, R5
        '{64'h0000_0000_0123_ABCD, 13'd7, 1'b0, 1'b0, 1'b0, K_HIT,  64'h0055_A000, 3'b100}, // R2 64K, R6
        '{64'h0000_0000_0123_ABCD, 13'd7, 1'b1, 1'b0, 1'b0, K_FLT,  64'h0,         3'b000}, // R7 write
        '{64'h0000_0001_0012_3456, 13'd7, 1'b0, 1'b0, 1'b0, K_HIT,  64'h0AD2_3000, 3'b110}, // R2 4M
        '{64'h0000_0001_0012_3456, 13'd7, 1'b0, 1'b1, 1'b0, K_FLT,  64'h0,         3'b000}, // R7 priv
        '{64'h0000_0000_000F_FFFF, 13'd3, 1'b0, 1'b0, 1'b0, K_HIT,  64'h0017_F000, 3'b110}, // R2 512K, R3
        '{64'h0000_0000_000F_FFFF, 13'd7, 1'b0, 1'b0, 1'b0, K_MISS, 64'h0,         3'b000}, // R3 ctx
        '{64'h0000_0000_7000_0010, 13'd7, 1'b0, 1'b0, 1'b0, K_HIT,  64'h0300_0000, 3'b100}, // R4
        '{64'h0000_0000_9000_0000, 13'd7, 1'b0, 1'b0, 1'b0, K_FLT,  64'h0,         3'b000}, // R7 invalid
        '{64'h0000_0000_0123_ABCD, 13'd7, 1'b1, 1'b0, 1'b1, K_HIT,  64'h0055_A000, 3'b001}, // R6 fetch
        '{64'h0000_0000_5555_0000, 13'd7, 1'b0, 1'b0, 1'b0, K_MISS, 64'h0,         3'b000}, // R9
        '{64'h0000_0000_0124_0000, 13'd7, 1'b0, 1'b0, 1'b0, K_MISS, 64'h0,         3'b000}, // R2 edge
        '{64'h0000_0001_003F_FFFF, 13'd7, 1'b0, 1'b0, 1'b0, K_HIT,  64'h0AFF_F000, 3'b110}  // R5 edge
    };

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic load(input logic [5:0] idx, input logic [63:0] tg, input logic [63:0] tt);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_tag = tg; wr_tte = tt;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic lookup(input logic [63:0] a, input logic [12:0] cx, input logic w,
                          input logic u, input logic f, input logic clr);
        @(negedge clk);
        ctx = cx; req_addr = a; req_write = w; req_user = u; req_fetch = f;
        fsr_clr = clr; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; fsr_clr = 1'b0;
    endtask

    function automatic logic [3:0] kind_now();
        return {rsp_hit, rsp_miss, rsp_fault, rsp_bypass};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; xl_en = 1'b1; ctx = '0; wr_en = 1'b0; wr_idx = '0;
        wr_tag = '0; wr_tte = '0; req_valid = 1'b0; req_addr = '0;
        req_write = 1'b0; req_user = 1'b0; req_fetch = 1'b0; fsr_clr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 / R8: reset state
        check("R1", "valid after reset", {63'h0, rsp_valid}, 64'h0);
        check("R8", "fsr after reset", {60'h0, fsr}, 64'h0);
        check("R8", "far after reset", far, 64'h0);

        // R11: entries through the write port
        load(6'd5,  64'h0000_0000_0040_0007, 64'h8000_0000_1234_6002);
        load(6'd9,  64'h0000_0000_0123_0007, 64'hA000_0000_0055_0000);
        load(6'd12, 64'h0000_0001_0000_0007, 64'hE000_0000_0AC0_0006);
        load(6'd20, 64'h0000_0000_0008_0003, 64'hC000_0000_0010_0002);
        load(6'd30, 64'h0000_0000_7000_0007, 64'h8000_0000_0300_0000);
        load(6'd31, 64'h0000_0000_7000_0007, 64'h8000_0000_0400_0000);
        load(6'd40, 64'h0000_0000_9000_0007, 64'h0000_0000_0500_0002);

        for (int i = 0; i < NV; i++) begin
            lookup(VEC[i].addr, VEC[i].cx, VEC[i].wr, VEC[i].usr, VEC[i].fet, 1'b0);
            check("R7", $sformatf("row %0d outcome", i), {60'h0, kind_now()}, {60'h0, VEC[i].kind});
            check("R5", $sformatf("row %0d paddr", i), rsp_paddr, VEC[i].pa);
            check("R6", $sformatf("row %0d rights", i), {61'h0, rsp_rd, rsp_wr, rsp_ex}, {61'h0, VEC[i].perm});
        end

        // R12: clear pulse
        @(negedge clk); fsr_clr = 1'b1;
        @(negedge clk); fsr_clr = 1'b0;
        check("R12", "fsr cleared", {60'h0, fsr}, 64'h0);

        // R8: first fault, user write to read-only page
        lookup(64'h0000_0000_0123_ABCD, 13'd7, 1'b1, 1'b1, 1'b0, 1'b0);
        check("R8", "fsr first fault", {60'h0, fsr}, 64'hD);
        check("R8", "far first fault", far, 64'h0000_0000_0123_ABCD);
        // R8: second fault flags overflow
        lookup(64'h0000_0001_0012_3456, 13'd7, 1'b0, 1'b1, 1'b0, 1'b0);
        check("R8", "fsr overflow", {60'h0, fsr}, 64'hB);
        check("R8", "far second fault", far, 64'h0000_0001_0012_3456);
        // R8: hit leaves status alone
        lookup(64'h0000_0000_0040_1ABC, 13'd7, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R8", "fsr after hit", {60'h0, fsr}, 64'hB);
        check("R8", "far after hit", far, 64'h0000_0001_0012_3456);

        // R1: idle cycle
        @(negedge clk);
        check("R1", "no request", {60'h0, kind_now()}, 64'h0);

        // R10: pass-through
        xl_en = 1'b0;
        lookup(64'hDEAD_BEEF_0000_1234, 13'd7, 1'b1, 1'b1, 1'b0, 1'b0);
        check("R10", "bypass outcome", {60'h0, kind_now()}, {60'h0, K_PASS});
        check("R10", "bypass paddr", rsp_paddr, 64'hDEAD_BEEF_0000_1234);
        check("R10", "bypass data rights", {61'h0, rsp_rd, rsp_wr, rsp_ex}, 64'h6);
        lookup(64'h0000_0000_9000_0000, 13'd7, 1'b0, 1'b0, 1'b1, 1'b0);
        check("R10", "bypass fetch rights", {61'h0, rsp_rd, rsp_wr, rsp_ex}, 64'h1);
        check("R10", "bypass skips fault table", {60'h0, fsr}, 64'hB);
        xl_en = 1'b1;

        // R4 / R11: a lower-indexed duplicate takes over at once
        load(6'd2, 64'h0000_0000_7000_0007, 64'h8000_0000_0200_0000);
        lookup(64'h0000_0000_7000_0010, 13'd7, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R4", "lowest index wins", rsp_paddr, 64'h0200_0000);
        check("R11", "new entry hit", {60'h0, kind_now()}, {60'h0, K_HIT});

        // R7 / R12: reset entries are invalid; a fault coinciding with clear has no overflow
        lookup(64'h0000_0000_0000_0800, 13'd0, 1'b0, 1'b0, 1'b0, 1'b1);
        check("R7", "reset entry faults", {60'h0, kind_now()}, {60'h0, K_FLT});
        check("R12", "clear with fault", {60'h0, fsr}, 64'h1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule